// File: doc/BRIEF.md
# Variable-Latency In-Order Pipeline Interlock

This block is a compact in-order integer pipeline with five stages: fetch, decode, operand read, execute and writeback. Each instruction names an operation (add, subtract, multiply, divide), a destination register and two source registers. The execute stage stays occupied for a number of cycles that depends on the operation. Only one instruction is in execute at a time. While execute is occupied, the stages in front of it hold their contents and writeback receives a bubble.

Results leave execute on its final cycle and are bypassed straight into operand read. A dependent instruction therefore starts execute in the cycle right after its latest producer finishes, and never later. An instruction that sits in operand read while its producer is in writeback also receives the value through a bypass.

The program is written into a small internal instruction store through a load port while reset is held. After reset is released, the block fetches from address 0, retires `prog_len` instructions, then raises `done` and freezes its cycle and retire counters.

Control is held by two state machines. The fetch controller has three states. It moves from fetching (`CT_FETCH`) to draining (`CT_DRAIN`) on the cycle the last instruction is fetched. It moves from draining to finished (`CT_DONE`) on the cycle the last instruction leaves writeback, and stays finished until reset. The execute unit moves from idle (`EX_IDLE`) to running (`EX_RUN`) when an instruction is accepted. On its final cycle it returns to idle, or it stays running if the next instruction is accepted in that same cycle.

Top module: `vlat_pipe`

## Requirements
- R1: An instruction word is 11 bits: bits [10:9] hold the operation (0 add, 1 subtract, 2 multiply, 3 divide), bits [8:6] the destination, bits [5:3] the first source and bits [2:0] the second source. Results are 16 bits. Add and subtract wrap, multiply keeps the low 16 bits of the product, divide is unsigned, and dividing by zero yields 0xFFFF.
- R2: The block has eight 16-bit registers, indices 0 to 7, and index 0 is an ordinary register. Reset loads register k with k+1. A register is written at the end of its instruction's writeback cycle. `peek_val` shows register `peek_idx` combinationally.
- R3: Execute occupies 1 cycle for add and subtract, 2 cycles for multiply and 3 cycles for divide. It holds at most one instruction at a time.
- R4: While the instruction in execute is not in its final cycle, operand read holds its instruction unchanged, decode and fetch hold as well, and `wb_valid` is low in the following cycle.
- R5: Cycle 1 is the first cycle after reset is released. Instruction k (counted from 0) starts execute in cycle max(k+4, E+1), where E is the final execute cycle of instruction k-1 (0 for the first instruction). It ends execute after its latency. It appears on `wb_valid`, `wb_dst` and `wb_value` in the cycle after it ends execute.
- R6: An instruction reads the value written by its most recent earlier producer of each source register. This holds when that producer is finishing execute in the same cycle and when it is in writeback. Reading this way adds no cycles beyond R5.
- R7: An instruction with producers for both sources uses both results and starts execute in the cycle after the later producer finishes. Along a chain of dependent instructions, each link adds its producer's full execute latency.
- R8: `done` goes high on the clock edge that ends the writeback cycle of instruction `prog_len`-1, with `prog_len` at least 1. From then on `cycle_count` equals the number of that cycle, `retired_count` equals `prog_len`, and both stay fixed while `done` remains high.
- R9: While reset is held, every stage is empty, `wb_valid` and `done` are low, both counters are zero, fetch restarts at address 0, and the contents of the instruction store written through the load port are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write `load_word` into the instruction store |
| load_addr | input | 4 | Instruction store address for the write |
| load_word | input | 11 | Instruction word to store |
| prog_len | input | 5 | Number of instructions to run, from 1 to 16 |
| peek_idx | input | 3 | Register index to observe |
| peek_val | output | 16 | Current contents of register `peek_idx` |
| wb_valid | output | 1 | An instruction is in writeback this cycle |
| wb_dst | output | 3 | Destination of the instruction in writeback |
| wb_value | output | 16 | Result of the instruction in writeback |
| done | output | 1 | All instructions have retired |
| cycle_count | output | 16 | Cycles elapsed since the first fetch |
| retired_count | output | 16 | Instructions that have left writeback |

## Verification
The first program has only independent single-cycle instructions. Any bubble or stall there is a fault, so it separates plain stage timing from the interlock. The second program mixes multiply and divide with an instruction that depends on both and a chain after it. It shows whether the wait follows the later producer and whether each link adds its full latency. The third program feeds results through the execute bypass and the writeback bypass and divides by a freshly produced zero, which separates the two bypass paths and the corner-case arithmetic. A one-instruction program checks the minimal `done` timing and the counter freeze.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
    localparam int XLEN = 16;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_t;

    typedef struct packed {
        op_t   op;
        ridx_t dst;
        ridx_t sa;
        ridx_t sb;
    } instr_t;

    localparam int IW = $bits(instr_t);
endpackage

// File: rtl/vlp_regfile.sv
module vlp_regfile
    import vlp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ridx_t wa,
    input  word_t wd,
    input  ridx_t ra0,
    input  ridx_t ra1,
    input  ridx_t rp,
    output word_t rd0,
    output word_t rd1,
    output word_t rpd
);
    word_t regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) regs[k] <= word_t'(k + 1);
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];
    assign rpd = regs[rp];
endmodule

// File: rtl/vlp_opsel.sv
module vlp_opsel
    import vlp_pkg::*;
(
    input  ridx_t src,
    input  word_t rf_val,
    input  logic  ex_v,
    input  logic  ex_fin,
    input  ridx_t ex_rd,
    input  word_t ex_res,
    input  logic  wb_v,
    input  ridx_t wb_rd,
    input  word_t wb_val,
    output word_t val,
    output logic  raw
);
    // newest producer wins: execute result, then writeback, then the file
    always_comb begin
        if (ex_fin && src == ex_rd)     val = ex_res;
        else if (wb_v && src == wb_rd)  val = wb_val;
        else                            val = rf_val;
    end

    assign raw = ex_v && !ex_fin && (src == ex_rd);
endmodule

// File: rtl/vlp_exec.sv
module vlp_exec
    import vlp_pkg::*;
#(
    parameter int MUL_CYC = 2,
    parameter int DIV_CYC = 3,
    localparam int MAXC = (MUL_CYC > DIV_CYC) ? MUL_CYC : DIV_CYC,
    localparam int LW = $clog2(MAXC + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  op_t   op_in,
    input  word_t a_in,
    input  word_t b_in,
    input  ridx_t rd_in,
    output logic  busy,
    output logic  first,
    output logic  fin,
    output op_t   op_q,
    output ridx_t rd_q,
    output word_t res
);
    typedef enum logic {EX_IDLE, EX_RUN} ex_state_t;
    ex_state_t       st;
    word_t           a_q, b_q;
    logic [LW-1:0]   elapsed, lat_m1;

    always_comb begin
        unique case (op_q)
            OP_MUL:  lat_m1 = LW'(MUL_CYC - 1);
            OP_DIV:  lat_m1 = LW'(DIV_CYC - 1);
            default: lat_m1 = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= EX_IDLE;
            elapsed <= '0;
            op_q    <= OP_ADD;
            rd_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
        end else if (load) begin
            st      <= EX_RUN;
            elapsed <= '0;
            op_q    <= op_in;
            rd_q    <= rd_in;
            a_q     <= a_in;
            b_q     <= b_in;
        end else if (fin) begin
            st      <= EX_IDLE;
        end else if (st == EX_RUN) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign busy  = (st == EX_RUN);
    assign first = busy && (elapsed == '0);
    assign fin   = busy && (elapsed == lat_m1);

    always_comb begin
        unique case (op_q)
            OP_ADD: res = a_q + b_q;
            OP_SUB: res = a_q - b_q;
            OP_MUL: res = a_q * b_q;
            OP_DIV: res = (b_q == '0) ? '1 : a_q / b_q;
        endcase
    end
endmodule

// File: rtl/vlat_pipe.sv
module vlat_pipe
    import vlp_pkg::*;
#(
    parameter int IMEM_DEPTH = 16,
    parameter int MUL_CYC = 2,
    parameter int DIV_CYC = 3,
    parameter int CNT_W = 16,
    localparam int AW = $clog2(IMEM_DEPTH),
    localparam int PW = $clog2(IMEM_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [AW-1:0]    load_addr,
    input  logic [IW-1:0]    load_word,
    input  logic [PW-1:0]    prog_len,
    input  logic [RIDX-1:0]  peek_idx,
    output logic [XLEN-1:0]  peek_val,
    output logic             wb_valid,
    output logic [RIDX-1:0]  wb_dst,
    output logic [XLEN-1:0]  wb_value,
    output logic             done,
    output logic [CNT_W-1:0] cycle_count,
    output logic [CNT_W-1:0] retired_count
);
    typedef enum logic [1:0] {CT_FETCH, CT_DRAIN, CT_DONE} ctl_t;
    ctl_t state, state_nx;

    instr_t        imem [IMEM_DEPTH];
    logic [PW-1:0] pc;
    logic          id_v, of_v;
    instr_t        id_q, of_q;
    logic          wb_v_q;
    ridx_t         wb_rd_q;
    word_t         wb_val_q;

    logic  ex_v, ex_first, ex_fin;
    op_t   ex_op;
    ridx_t ex_rd;
    word_t ex_res;

    ridx_t src   [2];
    word_t rf_rd [2];
    word_t opv   [2];
    logic  raw   [2];

    logic ex_free, raw_hold, of_go, of_free, id_go, id_free;
    logic fetch_go, last_fetch, last_wb;

    always_ff @(posedge clk) begin
        if (load_en) imem[load_addr] <= instr_t'(load_word);
    end

    assign src[0] = of_q.sa;
    assign src[1] = of_q.sb;

    vlp_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(wb_v_q), .wa(wb_rd_q), .wd(wb_val_q),
        .ra0(src[0]), .ra1(src[1]), .rp(peek_idx),
        .rd0(rf_rd[0]), .rd1(rf_rd[1]), .rpd(peek_val)
    );

    for (genvar s = 0; s < 2; s++) begin : g_src
        vlp_opsel u_sel (
            .src(src[s]), .rf_val(rf_rd[s]),
            .ex_v(ex_v), .ex_fin(ex_fin), .ex_rd(ex_rd), .ex_res(ex_res),
            .wb_v(wb_v_q), .wb_rd(wb_rd_q), .wb_val(wb_val_q),
            .val(opv[s]), .raw(raw[s])
        );
    end

    vlp_exec #(.MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) u_ex (
        .clk(clk), .rst_n(rst_n),
        .load(of_go), .op_in(of_q.op), .a_in(opv[0]), .b_in(opv[1]), .rd_in(of_q.dst),
        .busy(ex_v), .first(ex_first), .fin(ex_fin),
        .op_q(ex_op), .rd_q(ex_rd), .res(ex_res)
    );

    // stall chain, back to front
    assign ex_free  = !ex_v || ex_fin;
    assign raw_hold = of_v && (raw[0] || raw[1]);
    assign of_go    = of_v && ex_free && !raw_hold;
    assign of_free  = !of_v || of_go;
    assign id_go    = id_v && of_free;
    assign id_free  = !id_v || id_go;
    assign last_wb  = wb_v_q && (retired_count == CNT_W'(prog_len) - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CT_FETCH;
        else        state <= state_nx;
    end

    // outputs and next state
    always_comb begin
        fetch_go   = 1'b0;
        last_fetch = 1'b0;
        done       = 1'b0;
        state_nx   = state;
        unique case (state)
            CT_FETCH: begin
                fetch_go   = id_free;
                last_fetch = id_free && (pc == prog_len - 1'b1);
                if (last_fetch) state_nx = CT_DRAIN;
            end
            CT_DRAIN: begin
                if (last_wb) state_nx = CT_DONE;
            end
            CT_DONE: begin
                done = 1'b1;
            end
            default: state_nx = CT_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc            <= '0;
            id_v          <= 1'b0;
            of_v          <= 1'b0;
            id_q          <= '0;
            of_q          <= '0;
            wb_v_q        <= 1'b0;
            wb_rd_q       <= '0;
            wb_val_q      <= '0;
            cycle_count   <= '0;
            retired_count <= '0;
        end else begin
            if (fetch_go) begin
                id_q <= imem[pc[AW-1:0]];
                id_v <= 1'b1;
                pc   <= pc + 1'b1;
            end else if (id_go) begin
                id_v <= 1'b0;
            end
            if (id_go) begin
                of_q <= id_q;
                of_v <= 1'b1;
            end else if (of_go) begin
                of_v <= 1'b0;
            end
            wb_v_q   <= ex_fin;
            wb_rd_q  <= ex_rd;
            wb_val_q <= ex_res;
            if (state != CT_DONE) begin
                cycle_count <= cycle_count + 1'b1;
                if (wb_v_q) retired_count <= retired_count + 1'b1;
            end
        end
    end

    assign wb_valid = wb_v_q;
    assign wb_dst   = wb_rd_q;
    assign wb_value = wb_val_q;
endmodule

// File: rtl/vlat_pipe_chk.sv
module vlat_pipe_chk
    import vlp_pkg::*;
#(
    parameter int MUL_CYC = 2,
    parameter int DIV_CYC = 3,
    parameter int PW = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ex_v,
    input logic             ex_first,
    input logic             ex_fin,
    input op_t              ex_op,
    input logic             of_v,
    input instr_t           of_q,
    input logic             wb_valid,
    input logic             done,
    input logic [CNT_W-1:0] retired_count,
    input logic [PW-1:0]    prog_len
);
    logic [7:0] occ;
    logic [7:0] want_m1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                occ <= '0;
        else if (!ex_v || ex_fin)  occ <= '0;
        else                       occ <= occ + 1'b1;
    end

    always_comb begin
        case (ex_op)
            OP_MUL:  want_m1 = 8'(MUL_CYC - 1);
            OP_DIV:  want_m1 = 8'(DIV_CYC - 1);
            default: want_m1 = 8'd0;
        endcase
    end

    // R3
    ex_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_fin |-> (occ == want_m1));

    // R3
    ex_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_first |-> (occ == 8'd0));

    // R4
    of_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_v && !ex_fin && of_v) |=> (of_v && $stable(of_q)));

    // R4
    wb_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_v && !ex_fin) |=> !wb_valid);

    // R5
    wb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(ex_fin));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(retired_count)));

    // R8
    ret_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retired_count <= CNT_W'(prog_len));
endmodule

bind vlat_pipe vlat_pipe_chk #(
    .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC), .PW(PW), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ex_v(ex_v), .ex_first(ex_first), .ex_fin(ex_fin), .ex_op(ex_op),
    .of_v(of_v), .of_q(of_q),
    .wb_valid(wb_valid), .done(done),
    .retired_count(retired_count), .prog_len(prog_len)
);

// File: tb/vlat_pipe_test.sv
`timescale 1ns/1ps
module vlat_pipe_test;
    import vlp_pkg::*;

    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int PW = 5;
    localparam int CW = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            load_en = 1'b0;
    logic [AW-1:0]   load_addr = '0;
    logic [IW-1:0]   load_word = '0;
    logic [PW-1:0]   prog_len = PW'(1);
    logic [2:0]      peek_idx = '0;
    logic [15:0]     peek_val;
    logic            wb_valid;
    logic [2:0]      wb_dst;
    logic [15:0]     wb_value;
    logic            done;
    logic [CW-1:0]   cycle_count, retired_count;

    vlat_pipe uut (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .load_addr(load_addr), .load_word(load_word),
        .prog_len(prog_len), .peek_idx(peek_idx), .peek_val(peek_val),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_value(wb_value),
        .done(done), .cycle_count(cycle_count), .retired_count(retired_count)
    );

    typedef struct { int cyc; int dst; int val; } exp_t;
    exp_t expq[$];

    int checks = 0;
    int errors = 0;
    int cyc;
    logic [IW-1:0] prog [DEPTH];
    int ref_rf [8];
    string t_tag = "R5";
    string v_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: compares each retirement against the scoreboard
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            exp_t e;
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R4 extra retire in cycle %0d: actual dst %0d expected none",
                         cyc + 1, wb_dst);
            end else begin
                e = expq.pop_front();
                chk(t_tag, cyc + 1, e.cyc, "retire cycle");
                chk(v_tag, int'(wb_dst), e.dst, "retire dst");
                chk(v_tag, int'(wb_value), e.val, "retire value");
            end
        end
    end

    function automatic int alu(int op, int a, int b);
        case (op)
            0: return (a + b) & 16'hFFFF;
            1: return (a - b) & 16'hFFFF;
            2: return (a * b) & 16'hFFFF;
            default: return (b == 0) ? 16'hFFFF : a / b;
        endcase
    endfunction

    function automatic int lat(int op);
        return (op == 2) ? 2 : (op == 3) ? 3 : 1;
    endfunction

    task automatic put(int i, int op, int d, int a, int b);
        prog[i] = {2'(op), 3'(d), 3'(a), 3'(b)};
    endtask

    task automatic print_summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // driver: loads a program under reset, fills the scoreboard, runs it
    task automatic run(int n, string tt, string vt);
        int prev_end, total;
        @(negedge clk);
        rst_n = 1'b0;
        t_tag = tt;
        v_tag = vt;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = AW'(i);
            load_word = prog[i];
        end
        @(negedge clk);
        load_en  = 1'b0;
        prog_len = PW'(n);
        chk("R9", int'(wb_valid), 0, "wb_valid in reset");
        chk("R9", int'(done), 0, "done in reset");
        chk("R9", int'(cycle_count), 0, "cycle_count in reset");
        chk("R9", int'(retired_count), 0, "retired_count in reset");
        for (int k = 0; k < 8; k++) begin
            peek_idx = 3'(k);
            #0.1;
            chk("R2", int'(peek_val), k + 1, "register reset value");
            ref_rf[k] = k + 1;
        end
        prev_end = 0;
        total = 0;
        for (int i = 0; i < n; i++) begin
            int op, d, a, b, v, s, e;
            op = int'(prog[i][10:9]);
            d  = int'(prog[i][8:6]);
            a  = int'(prog[i][5:3]);
            b  = int'(prog[i][2:0]);
            v  = alu(op, ref_rf[a], ref_rf[b]);
            ref_rf[d] = v;
            s = (i + 4 > prev_end + 1) ? i + 4 : prev_end + 1;
            e = s + lat(op) - 1;
            expq.push_back('{e + 1, d, v});
            prev_end = e;
            total = e + 1;
        end
        @(negedge clk);
        rst_n = 1'b1;
        wait (done);
        @(negedge clk);
        chk("R8", int'(cycle_count), total, "cycle_count at done");
        chk("R8", int'(retired_count), n, "retired_count at done");
        chk(tt, expq.size(), 0, "retirements still pending");
        for (int k = 0; k < 8; k++) begin
            peek_idx = 3'(k);
            #0.1;
            chk("R2", int'(peek_val), ref_rf[k], "final register");
        end
        repeat (3) @(negedge clk);
        chk("R8", int'(done), 1, "done held");
        chk("R8", int'(cycle_count), total, "cycle_count frozen");
        chk("R8", int'(retired_count), n, "retired_count frozen");
        expq.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog: actual no done expected done");
        print_summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);

        // independent single-cycle ops: retire in cycles 5..8
        put(0, 0, 1, 2, 3);
        put(1, 1, 4, 5, 6);
        put(2, 0, 5, 6, 7);
        put(3, 1, 6, 7, 0);
        run(4, "R5", "R1");

        // mixed latencies, a two-producer join, then a chain
        put(0, 2, 1, 1, 2);
        put(1, 3, 4, 7, 2);
        put(2, 0, 5, 1, 4);
        put(3, 1, 0, 5, 1);
        put(4, 2, 2, 0, 0);
        put(5, 0, 3, 2, 2);
        run(6, "R3", "R7");

        // execute and writeback bypasses, divide by a fresh zero
        put(0, 1, 0, 3, 3);
        put(1, 0, 7, 6, 6);
        put(2, 3, 1, 5, 0);
        put(3, 2, 2, 1, 1);
        put(4, 2, 3, 2, 7);
        put(5, 3, 4, 7, 4);
        put(6, 0, 0, 4, 3);
        run(7, "R4", "R6");

        // single instruction: minimal done timing
        put(0, 0, 2, 2, 2);
        run(1, "R5", "R1");

        print_summary();
        $finish;
    end
endmodule